// File: doc/BRIEF.md
# Floating-Point Min/Max Unit

This unit returns the smaller or the larger of two IEEE 754 binary floating-point operands. It handles single precision (32-bit) and double precision (64-bit), selected per operation, and gives a 5-bit exception vector laid out as the usual accrued floating-point flags. Only the invalid-operation bit, bit 4 (value 0x10), can ever be set.

The unit orders ordinary values numerically and treats -0.0 as strictly below +0.0. If exactly one operand is a NaN, the other operand is returned. If both operands are NaNs, the canonical quiet NaN is returned. Only a signaling NaN raises invalid. In single precision only the low 32 bits of each operand are used, and the result comes back NaN-boxed.

An operation is presented with `inValid` for one cycle. The registered result and flags appear one clock later, marked by `outValid`. The output registers hold their last value until the next accepted operation.

Top module: `fp_minmax_unit`

## Requirements
- R1: `outValid` is high in exactly the cycles that follow a cycle in which `inValid` was high at the rising edge. Result and flags are registered with one cycle of latency.
- R2: For two ordinary (non-NaN) operands, the result follows numeric order: the smaller for min (`inIsMax`=0) and the larger for max (`inIsMax`=1). The flags are 0x00.
- R3: -0.0 is ordered strictly below +0.0 in either operand position. min gives -0.0 and max gives +0.0, with flags 0x00.
- R4: A quiet NaN (all-ones exponent, mantissa MSB set) paired with an ordinary operand returns the ordinary operand, with flags 0x00.
- R5: A signaling NaN (all-ones exponent, mantissa MSB clear, mantissa nonzero) paired with an ordinary operand returns the ordinary operand. Flags are 0x10, the invalid bit at bit 4.
- R6: When both operands are NaNs, the result is the canonical quiet NaN. Flags are 0x10 if either NaN is signaling and 0x00 otherwise.
- R7: Flag bits 3..0 (divide-by-zero, overflow, underflow, inexact) are always zero.
- R8: With `inIsDouble`=0, bits 63..32 of both operands are ignored. The 32-bit result is placed in bits 31..0 and bits 63..32 are all ones. The single-precision canonical NaN is 0x7FC00000. The double-precision canonical NaN is 0x7FF8000000000000.
- R9: In cycles with `inValid` low, `outResult` and `outFlags` keep their previous values.
- R10: During reset, `outValid`, `outResult` and `outFlags` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| inValid | input | 1 | Operation strobe |
| inIsDouble | input | 1 | 1 = double precision, 0 = single precision |
| inIsMax | input | 1 | 1 = maximum, 0 = minimum |
| inOpA | input | 64 | First operand |
| inOpB | input | 64 | Second operand |
| outValid | output | 1 | Result valid, one cycle after `inValid` |
| outResult | output | 64 | Selected value or canonical NaN |
| outFlags | output | 5 | Exception flags, bit 4 = invalid |

## Verification
The assertions assume three things about the inputs: `inValid` is low while reset is active, the operands and selects carry known values whenever `inValid` is high, and reset lasts at least one clock edge. The stimulus meets all three. It holds `inValid` low through reset, changes inputs only on the falling clock edge, and drives fully defined bit patterns. In single-precision operations it deliberately puts arbitrary junk in the upper operand halves, so the bench can show that those bits are ignored.

// File: rtl/fmm_pkg.sv
package fmm_pkg;
  parameter int D_W     = 64;
  parameter int S_W     = 32;
  parameter int D_EXP_W = 11;
  parameter int S_EXP_W = 8;
  parameter int FLAG_W  = 5;
  localparam int D_MAN_W = D_W - 1 - D_EXP_W;
  localparam int S_MAN_W = S_W - 1 - S_EXP_W;
  localparam int MAG_W   = D_W - 1;
  localparam int BOX_W   = D_W - S_W;
  localparam int INV_BIT = FLAG_W - 1;

  localparam logic [D_W-1:0] CANON_D = {1'b0, {D_EXP_W{1'b1}}, 1'b1, {(D_MAN_W-1){1'b0}}};
  localparam logic [S_W-1:0] CANON_S = {1'b0, {S_EXP_W{1'b1}}, 1'b1, {(S_MAN_W-1){1'b0}}};

  typedef struct packed {
    logic capture;
    logic isDouble;
    logic isMax;
  } ctrlStrobes_t;
endpackage

// File: rtl/fmm_classify.sv
module fmm_classify
  import fmm_pkg::*;
(
  input  logic [D_W-1:0]   operand,
  input  logic             isDouble,
  output logic             isNan,
  output logic             isSnan,
  output logic             sign,
  output logic [MAG_W-1:0] mag
);
  logic [S_W-1:0] lowHalf;
  logic dExpOnes, dManNz, dQuiet;
  logic sExpOnes, sManNz, sQuiet;

  assign lowHalf  = operand[S_W-1:0];

  assign dExpOnes = &operand[D_W-2 -: D_EXP_W];
  assign dManNz   = |operand[D_MAN_W-1:0];
  assign dQuiet   = operand[D_MAN_W-1];

  assign sExpOnes = &lowHalf[S_W-2 -: S_EXP_W];
  assign sManNz   = |lowHalf[S_MAN_W-1:0];
  assign sQuiet   = lowHalf[S_MAN_W-1];

  always_comb begin
    if (isDouble) begin
      isNan  = dExpOnes && dManNz;
      isSnan = dExpOnes && dManNz && !dQuiet;
      sign   = operand[D_W-1];
      mag    = operand[MAG_W-1:0];
    end else begin
      isNan  = sExpOnes && sManNz;
      isSnan = sExpOnes && sManNz && !sQuiet;
      sign   = lowHalf[S_W-1];
      mag    = {{(MAG_W-S_W+1){1'b0}}, lowHalf[S_W-2:0]};
    end
  end
endmodule

// File: rtl/fmm_ctrl.sv
module fmm_ctrl
  import fmm_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  input  logic         inIsDouble,
  input  logic         inIsMax,
  output ctrlStrobes_t strobes,
  output logic         outValid
);
  always_comb begin
    strobes.capture  = inValid && rstN;
    strobes.isDouble = inIsDouble;
    strobes.isMax    = inIsMax;
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end
endmodule

// File: rtl/fmm_datapath.sv
module fmm_datapath
  import fmm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [D_W-1:0]    opA,
  input  logic [D_W-1:0]    opB,
  output logic [D_W-1:0]    resultQ,
  output logic [FLAG_W-1:0] flagsQ
);
  logic [D_W-1:0]   opV [2];
  logic [1:0]       nanV, snanV, signV;
  logic [MAG_W-1:0] magV [2];

  assign opV[0] = opA;
  assign opV[1] = opB;

  generate
    for (genvar i = 0; i < 2; i++) begin : g_cls
      fmm_classify u_cls (
        .operand (opV[i]),
        .isDouble(strobes.isDouble),
        .isNan   (nanV[i]),
        .isSnan  (snanV[i]),
        .sign    (signV[i]),
        .mag     (magV[i])
      );
    end
  endgenerate

  logic           aLess, pickA;
  logic [D_W-1:0] chosen, canon, resultD;
  logic [FLAG_W-1:0] flagsD;

  always_comb begin
    if (signV[0] != signV[1]) aLess = signV[0];
    else if (signV[0])        aLess = magV[0] > magV[1];
    else                      aLess = magV[0] < magV[1];

    if (nanV[0])      pickA = 1'b0;
    else if (nanV[1]) pickA = 1'b1;
    else              pickA = strobes.isMax ? !aLess : aLess;

    chosen = pickA ? opA : opB;
    canon  = strobes.isDouble ? CANON_D : {{BOX_W{1'b1}}, CANON_S};

    if (&nanV)                 resultD = canon;
    else if (strobes.isDouble) resultD = chosen;
    else                       resultD = {{BOX_W{1'b1}}, chosen[S_W-1:0]};

    flagsD          = '0;
    flagsD[INV_BIT] = |snanV;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resultQ <= '0;
      flagsQ  <= '0;
    end else if (strobes.capture) begin
      resultQ <= resultD;
      flagsQ  <= flagsD;
    end
  end
endmodule

// File: rtl/fp_minmax_unit.sv
module fp_minmax_unit
  import fmm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              inIsDouble,
  input  logic              inIsMax,
  input  logic [D_W-1:0]    inOpA,
  input  logic [D_W-1:0]    inOpB,
  output logic              outValid,
  output logic [D_W-1:0]    outResult,
  output logic [FLAG_W-1:0] outFlags
);
  ctrlStrobes_t strobes;

  fmm_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   (inValid),
    .inIsDouble(inIsDouble),
    .inIsMax   (inIsMax),
    .strobes   (strobes),
    .outValid  (outValid)
  );

  fmm_datapath u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .opA    (inOpA),
    .opB    (inOpB),
    .resultQ(outResult),
    .flagsQ (outFlags)
  );
endmodule

// File: rtl/fmm_checker.sv
module fmm_checker
  import fmm_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic              inIsDouble,
  input logic              inIsMax,
  input logic [D_W-1:0]    inOpA,
  input logic [D_W-1:0]    inOpB,
  input logic              outValid,
  input logic [D_W-1:0]    outResult,
  input logic [FLAG_W-1:0] outFlags
);
  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
  a_r7_low_flags_zero: assert property (@(posedge clk) disable iff (!rstN)
    outFlags[INV_BIT-1:0] == '0);
  a_r8_nan_boxed: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !inIsDouble) |=> (outResult[D_W-1:S_W] == {BOX_W{1'b1}}));
  a_r6_result_source: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inIsDouble) |=>
      (outResult == $past(inOpA) || outResult == $past(inOpB) || outResult == CANON_D));
  a_r9_hold: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ($stable(outResult) && $stable(outFlags)));
  a_r2_select_known: assert property (@(posedge clk) disable iff (!rstN)
    inValid |-> !$isunknown({inIsMax, inIsDouble}));
endmodule

bind fp_minmax_unit fmm_checker u_chk (.*);

// File: tb/fp_minmax_unit_bench.sv
`timescale 1ns/1ps
module fp_minmax_unit_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0, inIsDouble = 1'b0, inIsMax = 1'b0;
  logic [63:0] inOpA = '0, inOpB = '0;
  logic        outValid;
  logic [63:0] outResult;
  logic [4:0]  outFlags;

  always #4 clk = ~clk;

  fp_minmax_unit u_fp_minmax_unit (.*);

  typedef struct {
    logic [63:0] res;
    logic [4:0]  flg;
    string       tag;
  } expItem_t;

  expItem_t q[$];
  int total = 0, bad = 0;
  logic [63:0] lastRes = '0;
  logic [4:0]  lastFlg = '0;
  bit done = 0;

  localparam logic [63:0] JUNK = 64'hDEADBEEF_00000000;
  localparam logic [63:0] BOX  = 64'hFFFFFFFF_00000000;

  task automatic send(input bit dbl, input bit mx, input logic [63:0] a, input logic [63:0] b,
                      input logic [63:0] eRes, input logic [4:0] eFlg, input string tag);
    expItem_t it;
    @(negedge clk);
    inValid = 1'b1; inIsDouble = dbl; inIsMax = mx; inOpA = a; inOpB = b;
    it.res = eRes; it.flg = eFlg; it.tag = tag;
    q.push_back(it);
    lastRes = eRes; lastFlg = eFlg;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b0;
      inOpA = 64'h0123456789ABCDEF; inOpB = 64'hFEDCBA9876543210;
    end
  endtask

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rstN && !done) begin
      if (outValid) begin
        if (q.size() == 0) check(0, "R1 unexpected outValid", 64'd1, 64'd0);
        else begin
          expItem_t it;
          it = q.pop_front();
          check(outResult == it.res, it.tag, outResult, it.res);
          check(outFlags == it.flg, it.tag, {59'd0, outFlags}, {59'd0, it.flg});
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(outValid == 1'b0, "R10 reset valid", {63'd0, outValid}, 64'd0);
    check(outResult == '0, "R10 reset result", outResult, 64'd0);
    check(outFlags == '0, "R10 reset flags", {59'd0, outFlags}, 64'd0);
    @(negedge clk) rstN = 1'b1;

    // R2 ordinary order, double
    send(1, 1, 64'h400921FB53C8D4F1, 64'h3E45798EE2308C3A, 64'h400921FB53C8D4F1, 5'h00, "R2 max pi,tiny d");
    send(1, 1, 64'hBFF0000000000000, 64'hC000000000000000, 64'hBFF0000000000000, 5'h00, "R2 max -1,-2 d");
    send(1, 0, 64'hBFF0000000000000, 64'hC000000000000000, 64'hC000000000000000, 5'h00, "R2 min -1,-2 d");
    send(1, 0, 64'h3FF0000000000000, 64'hBFF0000000000000, 64'hBFF0000000000000, 5'h00, "R2 min 1,-1 d");
    // R3 signed zeros
    send(1, 0, 64'h8000000000000000, 64'h0, 64'h8000000000000000, 5'h00, "R3 min -0,+0 d");
    send(1, 0, 64'h0, 64'h8000000000000000, 64'h8000000000000000, 5'h00, "R3 min +0,-0 d");
    send(1, 1, 64'h8000000000000000, 64'h0, 64'h0, 5'h00, "R3 max -0,+0 d");
    send(1, 1, 64'h0, 64'h8000000000000000, 64'h0, 5'h00, "R3 max +0,-0 d");
    // R4 quiet NaN with number
    send(1, 0, 64'h7FF8000000000000, 64'h3FF0000000000000, 64'h3FF0000000000000, 5'h00, "R4 qnan,1 d");
    send(1, 1, 64'hBFF0000000000000, 64'hFFF8000000000123, 64'hBFF0000000000000, 5'h00, "R4 -1,qnan d");
    // R5 signaling NaN with number
    send(1, 1, 64'h7FF0000000000001, 64'h3FF0000000000000, 64'h3FF0000000000000, 5'h10, "R5 snan,1 d");
    send(1, 0, 64'hC000000000000000, 64'h7FF4000000000000, 64'hC000000000000000, 5'h10, "R5 -2,snan d");
    // R6 both NaN
    send(1, 1, 64'h7FF8000000000000, 64'h7FF8000000000055, 64'h7FF8000000000000, 5'h00, "R6 qnan,qnan d");
    send(1, 0, 64'h7FF0000000000001, 64'h7FF8000000000055, 64'h7FF8000000000000, 5'h10, "R6 snan,qnan d");
    idle(2);

    // R8 single precision, upper halves junk
    send(0, 1, JUNK | 64'h40490FDB, JUNK | 64'h322BCC77, BOX | 64'h40490FDB, 5'h00, "R8 R2 max pi,tiny s");
    send(0, 1, JUNK | 64'hBF800000, 64'h12345678_C0000000, BOX | 64'hBF800000, 5'h00, "R8 R2 max -1,-2 s");
    send(0, 0, JUNK | 64'h80000000, JUNK | 64'h00000000, BOX | 64'h80000000, 5'h00, "R8 R3 min -0,+0 s");
    send(0, 1, JUNK | 64'h00000000, JUNK | 64'h80000000, BOX | 64'h00000000, 5'h00, "R8 R3 max +0,-0 s");
    send(0, 1, JUNK | 64'h7F800001, JUNK | 64'h3F800000, BOX | 64'h3F800000, 5'h10, "R8 R5 snan,1 s");
    send(0, 0, JUNK | 64'h3F800000, JUNK | 64'h7FC12345, BOX | 64'h3F800000, 5'h00, "R8 R4 1,qnan s");
    send(0, 1, JUNK | 64'h7FC00000, JUNK | 64'hFFC00001, BOX | 64'h7FC00000, 5'h00, "R8 R6 qnan,qnan s");
    send(0, 0, JUNK | 64'hFF800005, JUNK | 64'h7FC00000, BOX | 64'h7FC00000, 5'h10, "R8 R6 snan,qnan s");
    // R8 upper half looks like a NaN in double but must be ignored
    send(0, 0, 64'h7FF00000_3F800000, 64'h7FF00001_40000000, BOX | 64'h3F800000, 5'h00, "R8 upper ignored s");

    idle(4);
    while (q.size() != 0) @(negedge clk);
    // R9 hold after idle cycles
    check(outResult == lastRes, "R9 hold result", outResult, lastRes);
    check(outFlags == lastFlg, "R9 hold flags", {59'd0, outFlags}, {59'd0, lastFlg});
    check(outValid == 1'b0, "R1 valid low when idle", {63'd0, outValid}, 64'd0);
    // R7 flags low bits across an invalid case
    send(1, 0, 64'h7FF0000000000002, 64'h7FF0000000000003, 64'h7FF8000000000000, 5'h10, "R7 R6 snan,snan d");
    idle(3);
    check(outFlags[3:0] == 4'd0, "R7 low flags", {59'd0, outFlags}, 64'h10);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule